// File: doc/BRIEF.md
# SM3 Compression Round Engine

This block performs the 64-round compression step of the SM3 hash, one round per clock cycle. The caller presents a 256-bit chaining value and a 512-bit message block and pulses `start`. The engine captures both. It expands the message words internally and steps through the rounds. It then raises `done` for one cycle, and `state_out` carries the eight updated working words at that point.

Padding the message and XOR-ing the result with the incoming chaining value are left to the caller. The round count is a parameter with a default of 64. A shorter count exists only to expose intermediate rounds, such as the boundary where the round functions change.

Top module: `sm3_round_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy` and `done` are 0 and `state_out` is all zeros.
- R2: A `start` sampled high while `busy` is 0 captures `state_in` and `msg_in`, and `busy` is 1 from the next cycle.
- R3: A `start` sampled while `busy` is 1 is ignored, and the running computation finishes with its original inputs.
- R4: `done` is high for exactly one cycle, NUM_ROUNDS+1 cycles after the accepted start, and `busy` is 0 in that cycle.
- R5: At `done`, `state_out` equals NUM_ROUNDS SM3 rounds applied to the captured inputs, with all additions modulo 2^32. Word A sits in `state_in[255:224]` and `state_out[255:224]`, and words B to H follow toward bit 0. Message word W0 sits in `msg_in[511:480]`, and W1 to W15 follow toward bit 0. Round j uses W_j, and W'_j = W_j ^ W_(j+4).
- R6: Rounds 0 to 15 use X^Y^Z for both Boolean functions and the constant 0x79CC4519. From round 16 on, FF is the majority function, GG is (X&Y)|(~X&Z), and the constant is 0x7A879D8A. The constant is rotated left by j mod 32 before use.
- R7: Each round sets the words as follows: A to TT1, B to old A, C to old B rotated left 9, D to old C, E to P0(TT2), F to old E, G to old F rotated left 19, H to old G. TT1 = FF(A,B,C)+D+SS2+W'_j and TT2 = GG(E,F,G)+H+SS1+W_j. SS1 = ((A<<<12)+E+T_j)<<<7 and SS2 = SS1^(A<<<12).
- R8: After `done`, `state_out` holds its value until the next accepted start, whatever `state_in` and `msg_in` do.
- R9: Each word from W16 on is P1(W[j-16]^W[j-9]^(W[j-3]<<<15)) ^ (W[j-13]<<<7) ^ W[j-6]. The permutations are P1(X)=X^(X<<<15)^(X<<<23) and P0(X)=X^(X<<<9)^(X<<<17).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a compression when idle |
| state_in | input | 256 | Initial working words A..H, A in the top word |
| msg_in | input | 512 | Message block W0..W15, W0 in the top word |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| state_out | output | 256 | Working words A..H after the last round |

## Verification
A known-answer block checks the complete 64-round result. In that run the constant rotation wraps past j=32 and the expansion has to stay correct to W67. A wrong rotation amount or a wrong expansion tap would therefore corrupt every later word. A second engine, built with 17 rounds, isolates the function switch at round 16: if the switch were off by one round, the 17-round result would differ from the independent model. The bench pulses `start` in the middle of a run and also perturbs the inputs after `done`. A design that restarted, or that let its output follow its inputs, would then show a changed result.

// File: rtl/sm3_pkg.sv
package sm3_pkg;

  localparam int WORD_W = 32;
  localparam int NWORDS = 8;
  localparam int MSG_WORDS = 16;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
    word_t f;
    word_t g;
    word_t h;
  } sm3_state_t;

  localparam word_t K_LOW  = 32'h79CC4519;
  localparam word_t K_HIGH = 32'h7A879D8A;

  function automatic word_t rotl(word_t x, logic [4:0] n);
    return (x << n) | (x >> (6'd32 - {1'b0, n}));
  endfunction

  function automatic word_t perm0(word_t x);
    return x ^ rotl(x, 5'd9) ^ rotl(x, 5'd17);
  endfunction

  function automatic word_t perm1(word_t x);
    return x ^ rotl(x, 5'd15) ^ rotl(x, 5'd23);
  endfunction

  function automatic word_t bool_ff(word_t x, word_t y, word_t z, logic late);
    return late ? ((x & y) | (x & z) | (y & z)) : (x ^ y ^ z);
  endfunction

  function automatic word_t bool_gg(word_t x, word_t y, word_t z, logic late);
    return late ? ((x & y) | (~x & z)) : (x ^ y ^ z);
  endfunction

endpackage

// File: rtl/sm3_msg_window.sv
module sm3_msg_window
  import sm3_pkg::*;
#(
  parameter int DEPTH = MSG_WORDS
) (
  input  logic                    clk,
  input  logic                    load,
  input  logic                    shift,
  input  logic [DEPTH*WORD_W-1:0] msg,
  output word_t                   w_cur,
  output word_t                   w_derived
);
  // Window slot k holds W[j+k] during round j; the new word is W[j+DEPTH].
  localparam int TAP_M9  = DEPTH - 9;
  localparam int TAP_M3  = DEPTH - 3;
  localparam int TAP_M13 = DEPTH - 13;
  localparam int TAP_M6  = DEPTH - 6;
  localparam int LEAD    = 4;

  word_t win [DEPTH];
  word_t fresh;

  always_comb begin
    fresh = perm1(win[0] ^ win[TAP_M9] ^ rotl(win[TAP_M3], 5'd15))
            ^ rotl(win[TAP_M13], 5'd7) ^ win[TAP_M6];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == DEPTH - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (load)       win[i] <= msg[(DEPTH-1-i)*WORD_W +: WORD_W];
        else if (shift) win[i] <= fresh;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (load)       win[i] <= msg[(DEPTH-1-i)*WORD_W +: WORD_W];
        else if (shift) win[i] <= win[i+1];
      end
    end
  end

  assign w_cur     = win[0];
  assign w_derived = win[0] ^ win[LEAD];

endmodule

// File: rtl/sm3_round_datapath.sv
module sm3_round_datapath
  import sm3_pkg::*;
#(
  parameter int CNT_W        = 6,
  parameter int SWITCH_ROUND = 16
) (
  input  sm3_state_t       cur,
  input  word_t            w_cur,
  input  word_t            w_derived,
  input  logic [CNT_W-1:0] round,
  output sm3_state_t       nxt
);
  logic [31:0] rnd_ext;
  logic        late;
  logic [4:0]  amt;
  word_t       t_rot, a12, ss1, ss2, tt1, tt2;

  always_comb begin
    rnd_ext = 32'(round);
    late    = (rnd_ext >= 32'(SWITCH_ROUND));
    amt     = rnd_ext[4:0];
    t_rot   = rotl(late ? K_HIGH : K_LOW, amt);
    a12     = rotl(cur.a, 5'd12);
    ss1     = rotl(a12 + cur.e + t_rot, 5'd7);
    ss2     = ss1 ^ a12;
    tt1     = bool_ff(cur.a, cur.b, cur.c, late) + cur.d + ss2 + w_derived;
    tt2     = bool_gg(cur.e, cur.f, cur.g, late) + cur.h + ss1 + w_cur;
    nxt.a   = tt1;
    nxt.b   = cur.a;
    nxt.c   = rotl(cur.b, 5'd9);
    nxt.d   = cur.c;
    nxt.e   = perm0(tt2);
    nxt.f   = cur.e;
    nxt.g   = rotl(cur.f, 5'd19);
    nxt.h   = cur.g;
  end

endmodule

// File: rtl/sm3_round_ctrl.sv
module sm3_round_ctrl #(
  parameter int NUM_ROUNDS = 64,
  parameter int CNT_W      = $clog2(NUM_ROUNDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             load,
  output logic             step,
  output logic [CNT_W-1:0] round,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_ROUNDS - 1);

  assign load = start & ~busy;
  assign step = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      round <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        round <= '0;
      end else if (busy) begin
        if (round == LAST) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          round <= '0;
        end else begin
          round <= round + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sm3_round_engine.sv
module sm3_round_engine
  import sm3_pkg::*;
#(
  parameter int NUM_ROUNDS   = 64,
  parameter int SWITCH_ROUND = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [NWORDS*WORD_W-1:0]      state_in,
  input  logic [MSG_WORDS*WORD_W-1:0]   msg_in,
  output logic                          busy,
  output logic                          done,
  output logic [NWORDS*WORD_W-1:0]      state_out
);
  localparam int CNT_W = $clog2(NUM_ROUNDS);

  logic             load, step;
  logic [CNT_W-1:0] round;
  word_t            w_cur, w_derived;
  sm3_state_t       state_q, state_nxt;

  sm3_round_ctrl #(.NUM_ROUNDS(NUM_ROUNDS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .load(load), .step(step),
    .round(round), .busy(busy), .done(done)
  );

  sm3_msg_window #(.DEPTH(MSG_WORDS)) u_win (
    .clk(clk), .load(load), .shift(step), .msg(msg_in),
    .w_cur(w_cur), .w_derived(w_derived)
  );

  sm3_round_datapath #(.CNT_W(CNT_W), .SWITCH_ROUND(SWITCH_ROUND)) u_dp (
    .cur(state_q), .w_cur(w_cur), .w_derived(w_derived),
    .round(round), .nxt(state_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)       state_q <= '0;
    else if (load) state_q <= sm3_state_t'(state_in);
    else if (step) state_q <= state_nxt;
  end

  assign state_out = state_q;

endmodule

// File: rtl/sm3_round_engine_chk.sv
module sm3_round_engine_chk #(
  parameter int NUM_ROUNDS = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [255:0] state_out
);
  logic [15:0] busy_cycles;

  always_ff @(posedge clk) begin
    if (rst)                busy_cycles <= '0;
    else if (start && !busy) busy_cycles <= '0;
    else if (busy)          busy_cycles <= busy_cycles + 16'd1;
  end

  // R4: single-cycle pulse
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R4: done never coincides with busy
  a_r4_done_idle: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R4: the pulse follows exactly NUM_ROUNDS busy cycles
  a_r4_round_count: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_cycles == 16'(NUM_ROUNDS)));
  // R2: accepted start raises busy
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R3: start while busy does not end or restart the run early
  a_r3_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> (busy || done));
  // R8: output stable while idle with no start
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(state_out));

endmodule

bind sm3_round_engine sm3_round_engine_chk #(.NUM_ROUNDS(NUM_ROUNDS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .state_out(state_out)
);

// File: tb/sim_sm3_round_engine.sv
module sim_sm3_round_engine;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         start1 = 1'b0;
  logic [255:0] state_in = '0;
  logic [511:0] msg_in = '0;
  logic         busy, done, busy1, done1;
  logic [255:0] state_out, state_out1;

  always #4 clk = ~clk;

  sm3_round_engine u0 (
    .clk(clk), .rst(rst), .start(start), .state_in(state_in), .msg_in(msg_in),
    .busy(busy), .done(done), .state_out(state_out)
  );

  sm3_round_engine #(.NUM_ROUNDS(17)) u1 (
    .clk(clk), .rst(rst), .start(start1), .state_in(state_in), .msg_in(msg_in),
    .busy(busy1), .done(done1), .state_out(state_out1)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [255:0] exp_q[$];
  string        tag_q[$];
  logic [255:0] last_exp;

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    int k = n % 32;
    if (k == 0) return x;
    return (x << k) | (x >> (32 - k));
  endfunction

  function automatic logic [31:0] pp1(logic [31:0] x);
    return x ^ rl(x, 15) ^ rl(x, 23);
  endfunction

  function automatic logic [31:0] pp0(logic [31:0] x);
    return x ^ rl(x, 9) ^ rl(x, 17);
  endfunction

  // Independent model written from R5, R6, R7, R9.
  function automatic logic [255:0] model(logic [255:0] v, logic [511:0] m, int nr);
    logic [31:0] w [68];
    logic [31:0] a, b, c, d, e, f, g, h, t, tj, s1, s2, t1, t2, fv, gv;
    for (int j = 0; j < 16; j++) w[j] = m[511 - 32*j -: 32];
    for (int j = 16; j < 68; j++) begin
      t = w[j-16] ^ w[j-9] ^ rl(w[j-3], 15);
      w[j] = pp1(t) ^ rl(w[j-13], 7) ^ w[j-6];
    end
    {a, b, c, d, e, f, g, h} = v;
    for (int j = 0; j < nr; j++) begin
      tj = rl((j < 16) ? 32'h79CC4519 : 32'h7A879D8A, j);
      s1 = rl(rl(a, 12) + e + tj, 7);
      s2 = s1 ^ rl(a, 12);
      fv = (j < 16) ? (a ^ b ^ c) : ((a & b) | (a & c) | (b & c));
      gv = (j < 16) ? (e ^ f ^ g) : ((e & f) | (~e & g));
      t1 = fv + d + s2 + (w[j] ^ w[j+4]);
      t2 = gv + h + s1 + w[j];
      d = c; c = rl(b, 9); b = a; a = t1;
      h = g; g = rl(f, 19); f = e; e = pp0(t2);
    end
    return {a, b, c, d, e, f, g, h};
  endfunction

  function automatic logic [511:0] rnd_msg();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom();
    return r;
  endfunction

  function automatic logic [255:0] rnd_state();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom();
    return r;
  endfunction

  // Monitor: pops the expected result when done pulses.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R4 actual=unexpected done expected=no done");
      end else begin
        chk(tag_q.pop_front(), state_out, exp_q.pop_front());
      end
    end
  end

  // Driver: push expectation, start, measure latency; optionally re-pulse start mid-run.
  task automatic run_block(logic [255:0] v, logic [511:0] m, logic [255:0] exp,
                           string tag, bit inject);
    int cyc;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    last_exp = exp;
    state_in = v; msg_in = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk("R2 busy after start", {255'd0, busy}, 256'd1);
    while (!done) begin
      if (inject && cyc == 10) begin
        start = 1'b1; state_in = ~v; msg_in = ~m;
      end else if (cyc == 13) begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk("R4 latency", 256'(cyc), 256'd65);
    chk("R4 busy low at done", {255'd0, busy}, 256'd0);
    @(negedge clk);
    chk("R4 done one cycle", {255'd0, done}, 256'd0);
  endtask

  localparam logic [255:0] IV = {32'h7380166f, 32'h4914b2b9, 32'h172442d7, 32'hda8a0600,
                                 32'ha96f30bc, 32'h163138aa, 32'he38dee4d, 32'hb0fb0e4e};
  localparam logic [255:0] ABC_HASH = {32'h66c7f0f4, 32'h62eeedd9, 32'hd1f2d46b, 32'hdc10e4e2,
                                       32'h4167c487, 32'h5cf2f7a2, 32'h297da02b, 32'h8f4ba8e0};

  initial begin
    #(200000 * 8);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [511:0] abc;
    logic [255:0] v;
    logic [511:0] m;
    abc = '0;
    abc[511:480] = 32'h61626380;
    abc[31:0]    = 32'h00000018;

    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 busy in reset", {255'd0, busy}, 256'd0);
    chk("R1 done in reset", {255'd0, done}, 256'd0);
    chk("R1 state in reset", state_out, 256'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 state after reset", state_out, 256'd0);

    // R5 R7 R9: known-answer block, full 64 rounds
    chk("R5 model check", model(IV, abc, 64) ^ IV, ABC_HASH);
    run_block(IV, abc, ABC_HASH ^ IV, "R5 R7 R9 known answer", 1'b0);

    // R8: perturb inputs after done, output must hold
    state_in = rnd_state(); msg_in = rnd_msg();
    repeat (6) @(negedge clk);
    chk("R8 hold after done", state_out, last_exp);

    // R5: several random blocks
    for (int k = 0; k < 4; k++) begin
      v = rnd_state(); m = rnd_msg();
      run_block(v, m, model(v, m, 64), "R5 random block", 1'b0);
    end
    // edge patterns: all zeros, all ones
    run_block('0, '0, model('0, '0, 64), "R5 zero block", 1'b0);
    run_block('1, '1, model('1, '1, 64), "R5 ones block", 1'b0);

    // R3: start pulsed while busy with different inputs
    v = rnd_state(); m = rnd_msg();
    run_block(v, m, model(v, m, 64), "R3 start ignored while busy", 1'b1);

    // R6: 17-round engine crosses the function switch at round 16
    v = rnd_state(); m = rnd_msg();
    state_in = v; msg_in = m; start1 = 1'b1;
    @(negedge clk);
    start1 = 1'b0;
    while (!done1) @(negedge clk);
    chk("R6 switch at round 16", state_out1, model(v, m, 17));
    v = IV; m = abc;
    state_in = v; msg_in = m; start1 = 1'b1;
    @(negedge clk);
    start1 = 1'b0;
    while (!done1) @(negedge clk);
    chk("R6 switch at round 16 known block", state_out1, model(v, m, 17));

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R4 actual=%0d pending expected=0 pending", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule